// File: doc/BRIEF.md
# Program Counter Sequencer with Skip

This block advances the 13-bit program counter of a small accumulator-style core and executes the subset of instructions that decide where the next fetch comes from. It can test one bit of a register location and skip the following instruction. It can also call a subroutine. It executes two clear instructions and a pair of literal and move instructions, which let software fill register locations. It holds 128 byte-wide register locations, a working register (W), a zero flag and an 8-entry circular return-address stack.

An instruction word is taken on any cycle where the valid strobe is high. A taken skip or a call then forces one discard cycle. In that cycle the flush output is high and the word already on the instruction input is dropped. Calls take their low 11 target bits from the instruction. The top two bits of the target come from bits 4:3 of the address-latch location, which is register location 0x0A.

Top module: `pcs_skip_seq`

## Requirements
- R1: After reset, fetch_addr_o is 0, flush_o is 0, zero_o is 0, and all register locations are 0, including the address latch at location 0x0A.
- R2: With instr_valid_i low and no flush pending, nothing changes. Otherwise a non-branch instruction advances fetch_addr_o by 1 and does not raise flush_o.
- R3: Skip-if-set has opcode bits [13:11]=3, bit select [9:7] and location [6:0]. If the selected bit is 1, fetch_addr_o advances by 2 and flush_o is high in the next cycle. If the bit is 0, fetch_addr_o advances by 1 with no flush.
- R4: Skip-if-clear (opcode 4, same fields) skips and flushes when the selected bit is 0. It advances by 1 with no flush when the bit is 1.
- R5: Call (opcode 5, target [10:0]) loads fetch_addr_o with {latch[4:3], target} and raises flush_o in the next cycle. Latch bits other than 4:3 have no effect.
- R6: Call pushes its own address plus 1 onto the return stack, and tos_o shows the latest pushed value. The stack has 8 entries and wraps with no overflow indication.
- R7: flush_o stays high for exactly one cycle. During that cycle fetch_addr_o holds, and the instruction word present has no effect.
- R8: Clear-register (opcode 1, location [6:0]) writes 0x00 to the location and sets zero_o. zero_o is cleared only by reset.
- R9: Clear-accumulator (opcode 2) writes 0x00 to W and sets zero_o.
- R10: Skip and call instructions leave zero_o unchanged.
- R11: Load-W (opcode 6, literal [7:0]) writes W. Store-W (opcode 7, location [6:0]) copies W into a location. Neither changes zero_o. Opcode 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 14 | Instruction word |
| instr_valid_i | input | 1 | Instruction word valid |
| fetch_addr_o | output | 13 | Program counter / fetch address |
| flush_o | output | 1 | Current cycle discards the fetched word |
| zero_o | output | 1 | Zero flag |
| tos_o | output | 13 | Most recently pushed return address |

## Verification
The bench skips on bit 7 and bit 0 of a stored pattern with both polarities. A wrong bit index or an inverted sense shows up as a fetch address off by one and a missing or spurious flush. It presents a clear-accumulator and a call during the discard cycle. A design that executed the dropped word would then set the zero flag or move the top of stack. Calls are made with the latch at 11, 01 and with only non-target bits set. A design that took the wrong latch bits, or let the other latch bits through, lands at the wrong target. Ten back-to-back calls check that the stack pointer wraps without corrupting the top entry.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CLRF = 3'd1,
    OP_CLRW = 3'd2,
    OP_SKS  = 3'd3,
    OP_SKC  = 3'd4,
    OP_CALL = 3'd5,
    OP_LDW  = 3'd6,
    OP_STW  = 3'd7
  } op_e;

  typedef struct packed {
    logic wr_f;       // write register location
    logic f_from_w;   // location data is W (else zero)
    logic clr_w;
    logic ld_w;
    logic set_z;
    logic is_skip;
    logic skip_on_set;
    logic is_call;
  } ctl_t;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
#(
  parameter int INSN_W = 14,
  parameter int ADDR_W = 7,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8,
  parameter int TGT_W  = 11
) (
  input  logic [INSN_W-1:0] insn_i,
  output ctl_t              ctl_o,
  output logic [ADDR_W-1:0] f_addr_o,
  output logic [BIT_W-1:0]  bsel_o,
  output logic [DATA_W-1:0] lit_o,
  output logic [TGT_W-1:0]  tgt_o
);
  op_e op;
  assign op       = op_e'(insn_i[INSN_W-1 -: 3]);
  assign f_addr_o = insn_i[ADDR_W-1:0];
  assign bsel_o   = insn_i[ADDR_W +: BIT_W];
  assign lit_o    = insn_i[DATA_W-1:0];
  assign tgt_o    = insn_i[TGT_W-1:0];

  always_comb begin
    ctl_o = '0;
    case (op)
      OP_CLRF: begin ctl_o.wr_f = 1'b1; ctl_o.set_z = 1'b1; end
      OP_CLRW: begin ctl_o.clr_w = 1'b1; ctl_o.set_z = 1'b1; end
      OP_SKS:  begin ctl_o.is_skip = 1'b1; ctl_o.skip_on_set = 1'b1; end
      OP_SKC:  ctl_o.is_skip = 1'b1;
      OP_CALL: ctl_o.is_call = 1'b1;
      OP_LDW:  ctl_o.ld_w = 1'b1;
      OP_STW:  begin ctl_o.wr_f = 1'b1; ctl_o.f_from_w = 1'b1; end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/pcs_regfile.sv
module pcs_regfile
  import pcs_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int DATA_W     = 8,
  parameter int LATCH_ADDR = 10,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int BIT_W     = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] f_addr_i,
  input  logic [BIT_W-1:0]  bsel_i,
  input  logic [DATA_W-1:0] lit_i,
  output logic              bit_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] latch_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] w_q;
  logic              z_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      w_q <= '0;
      z_q <= 1'b0;
    end else if (exec_i) begin
      if (ctl_i.wr_f)  mem_q[f_addr_i] <= ctl_i.f_from_w ? w_q : '0;
      if (ctl_i.clr_w)     w_q <= '0;
      else if (ctl_i.ld_w) w_q <= lit_i;
      if (ctl_i.set_z) z_q <= 1'b1;
    end
  end

  assign bit_o   = mem_q[f_addr_i][bsel_i];
  assign zero_o  = z_q;
  assign latch_o = mem_q[LATCH_ADDR];
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] tos_o
);
  logic [W-1:0]     ent_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;   // next free slot, wraps silently

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      ptr_q <= '0;
    end else if (push_i) begin
      ent_q[ptr_q] <= data_i;
      ptr_q        <= ptr_q + PTR_W'(1);
    end
  end

  assign tos_o = ent_q[ptr_q - PTR_W'(1)];
endmodule

// File: rtl/pcs_skip_seq.sv
module pcs_skip_seq
  import pcs_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int INSN_W      = 14,
  parameter int RF_DEPTH    = 128,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 8,
  parameter int LATCH_ADDR  = 10,
  parameter int HI_LSB      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] instr_i,
  input  logic              instr_valid_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic              flush_o,
  output logic              zero_o,
  output logic [PC_W-1:0]   tos_o
);
  localparam int ADDR_W = $clog2(RF_DEPTH);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int TGT_W  = INSN_W - 3;
  localparam int HI_W   = PC_W - TGT_W;

  ctl_t              ctl;
  logic [ADDR_W-1:0] f_addr;
  logic [BIT_W-1:0]  bsel;
  logic [DATA_W-1:0] lit;
  logic [TGT_W-1:0]  tgt;
  logic [DATA_W-1:0] latch;
  logic              bit_val;
  logic              exec, taken, push;
  logic [PC_W-1:0]   pc_q;
  logic              flush_q;

  pcs_decode #(
    .INSN_W(INSN_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W),
    .DATA_W(DATA_W), .TGT_W(TGT_W)
  ) u_dec (
    .insn_i(instr_i), .ctl_o(ctl), .f_addr_o(f_addr),
    .bsel_o(bsel), .lit_o(lit), .tgt_o(tgt)
  );

  pcs_regfile #(
    .DEPTH(RF_DEPTH), .DATA_W(DATA_W), .LATCH_ADDR(LATCH_ADDR)
  ) u_rf (
    .clk_i, .rst_ni, .exec_i(exec), .ctl_i(ctl), .f_addr_i(f_addr),
    .bsel_i(bsel), .lit_i(lit), .bit_o(bit_val), .zero_o(zero_o),
    .latch_o(latch)
  );

  pcs_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stk (
    .clk_i, .rst_ni, .push_i(push), .data_i(pc_q + PC_W'(1)), .tos_o(tos_o)
  );

  // the word present during a flush cycle is dropped
  assign exec  = instr_valid_i && !flush_q;
  assign taken = ctl.is_skip && (bit_val == ctl.skip_on_set);
  assign push  = exec && ctl.is_call;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= exec && (taken || ctl.is_call);
      if (exec) begin
        if (ctl.is_call) pc_q <= {latch[HI_LSB +: HI_W], tgt};
        else             pc_q <= pc_q + (taken ? PC_W'(2) : PC_W'(1));
      end
    end
  end

  assign fetch_addr_o = pc_q;
  assign flush_o      = flush_q;
endmodule

// File: rtl/pcs_skip_seq_chk.sv
module pcs_skip_seq_chk #(
  parameter int PC_W   = 13,
  parameter int INSN_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [INSN_W-1:0] instr_i,
  input logic              instr_valid_i,
  input logic [PC_W-1:0]   fetch_addr_o,
  input logic              flush_o,
  input logic              zero_o,
  input logic [PC_W-1:0]   tos_o
);
  logic [2:0] op;
  logic       go, is_skip, is_call;
  assign op      = instr_i[INSN_W-1 -: 3];
  assign go      = instr_valid_i && !flush_o;
  assign is_skip = (op == 3'd3) || (op == 3'd4);
  assign is_call = (op == 3'd5);

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_valid_i && !flush_o) |=> ($stable(fetch_addr_o) && !flush_o)); // R2
  AST_PLAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !is_skip && !is_call) |=> (fetch_addr_o == $past(fetch_addr_o) + PC_W'(1)) && !flush_o); // R2
  AST_SKIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && is_skip) |=> ((fetch_addr_o == $past(fetch_addr_o) + PC_W'(2)) && flush_o) ||
                        ((fetch_addr_o == $past(fetch_addr_o) + PC_W'(1)) && !flush_o)); // R3
  AST_CALL_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && is_call) |=> flush_o && (tos_o == $past(fetch_addr_o) + PC_W'(1))); // R6
  AST_FLUSH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R7
  AST_FLUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> ($stable(fetch_addr_o) && $stable(tos_o))); // R7
  AST_ZERO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> zero_o); // R8
  AST_BRANCH_NO_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && (is_skip || is_call) && !zero_o) |=> !zero_o); // R10
endmodule

bind pcs_skip_seq pcs_skip_seq_chk #(.PC_W(PC_W), .INSN_W(INSN_W)) u_chk (.*);

// File: tb/sim_pcs_skip_seq.sv
module sim_pcs_skip_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] instr = '0;
  logic        valid = 1'b0;
  logic [12:0] fetch_addr, tos;
  logic        flush, zero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [12:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcs_skip_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_valid_i(valid),
    .fetch_addr_o(fetch_addr), .flush_o(flush), .zero_o(zero), .tos_o(tos)
  );

  function automatic logic [13:0] e_clrf(input logic [6:0] f); return {3'd1, 4'd0, f}; endfunction
  function automatic logic [13:0] e_clrw(); return {3'd2, 11'd0}; endfunction
  function automatic logic [13:0] e_sks(input logic [6:0] f, input logic [2:0] b); return {3'd3, 1'b0, b, f}; endfunction
  function automatic logic [13:0] e_skc(input logic [6:0] f, input logic [2:0] b); return {3'd4, 1'b0, b, f}; endfunction
  function automatic logic [13:0] e_call(input logic [10:0] k); return {3'd5, k}; endfunction
  function automatic logic [13:0] e_ldw(input logic [7:0] l); return {3'd6, 3'd0, l}; endfunction
  function automatic logic [13:0] e_stw(input logic [6:0] f); return {3'd7, 4'd0, f}; endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] ins, input logic v);
    @(negedge clk);
    instr = ins;
    valid = v;
    @(posedge clk);
    #1;
  endtask

  // non-branch instruction, advances by one
  task automatic plain(input logic [13:0] ins);
    step(ins, 1'b1);
    exp_pc = exp_pc + 13'd1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; instr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = '0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 fetch_addr", fetch_addr, 0);
    check("R1 flush", flush, 0);
    check("R1 zero", zero, 0);
  endtask

  task automatic t_idle();
    step(e_clrw(), 1'b0);
    check("R2 idle addr", fetch_addr, exp_pc);
    check("R2 idle zero", zero, 0);
    plain('0);
    check("R2 nop addr", fetch_addr, exp_pc);
    check("R2 nop flush", flush, 0);
  endtask

  task automatic t_skip_set();
    plain(e_ldw(8'h81));
    plain(e_stw(7'h20));
    step(e_sks(7'h20, 3'd7), 1'b1);
    exp_pc = exp_pc + 13'd2;
    check("R3 set bit7 addr", fetch_addr, exp_pc);
    check("R3 set bit7 flush", flush, 1);
    check("R10 skip zero", zero, 0);
    step(e_clrw(), 1'b1); // dropped word
    check("R7 flush addr hold", fetch_addr, exp_pc);
    check("R7 flush one cycle", flush, 0);
    check("R7 dropped clrw", zero, 0);
    step(e_sks(7'h20, 3'd1), 1'b1);
    exp_pc = exp_pc + 13'd1;
    check("R3 clear bit1 addr", fetch_addr, exp_pc);
    check("R3 clear bit1 flush", flush, 0);
    step(e_sks(7'h20, 3'd0), 1'b1);
    exp_pc = exp_pc + 13'd2;
    check("R3 set bit0 addr", fetch_addr, exp_pc);
    check("R3 set bit0 flush", flush, 1);
    step('0, 1'b1);
  endtask

  task automatic t_skip_clr();
    step(e_skc(7'h20, 3'd1), 1'b1);
    exp_pc = exp_pc + 13'd2;
    check("R4 clear bit1 addr", fetch_addr, exp_pc);
    check("R4 clear bit1 flush", flush, 1);
    step('0, 1'b1);
    check("R4 flush addr hold", fetch_addr, exp_pc);
    step(e_skc(7'h20, 3'd7), 1'b1);
    exp_pc = exp_pc + 13'd1;
    check("R4 set bit7 addr", fetch_addr, exp_pc);
    check("R4 set bit7 flush", flush, 0);
  endtask

  task automatic do_call(input logic [10:0] k, input logic [1:0] hi, input string tag);
    logic [12:0] ret;
    ret = exp_pc + 13'd1;
    step(e_call(k), 1'b1);
    exp_pc = {hi, k};
    check({tag, " target"}, fetch_addr, exp_pc);
    check({tag, " flush"}, flush, 1);
    check({"R6 ", tag, " push"}, tos, ret);
    step(e_call(11'h3FF), 1'b1); // dropped word
    check("R7 call dropped in flush", tos, ret);
    check("R7 flush addr", fetch_addr, exp_pc);
  endtask

  task automatic t_call();
    do_reset();
    plain('0);
    do_call(11'h155, 2'b00, "R1 R5 latch reset");
    check("R10 call zero", zero, 0);
    plain(e_ldw(8'h18));
    plain(e_stw(7'h0A));
    do_call(11'h123, 2'b11, "R5 latch 11");
    plain(e_ldw(8'h08));
    plain(e_stw(7'h0A));
    do_call(11'h7FF, 2'b01, "R5 latch 01");
    plain(e_ldw(8'hE7));
    plain(e_stw(7'h0A));
    do_call(11'h001, 2'b00, "R5 other bits");
  endtask

  task automatic t_stack();
    for (int i = 0; i < 10; i++) begin
      do_call(11'h200 + 11'(i * 16), 2'b00, "R6 wrap");
      plain('0);
    end
  endtask

  task automatic t_clrw();
    do_reset();
    plain(e_ldw(8'h5A));
    check("R11 ldw zero", zero, 0);
    plain(e_clrw());
    check("R9 clrw zero", zero, 1);
    plain(e_stw(7'h31));
    step(e_skc(7'h31, 3'd6), 1'b1);
    exp_pc = exp_pc + 13'd2;
    check("R9 W cleared", fetch_addr, exp_pc);
    step('0, 1'b1);
  endtask

  task automatic t_clrf();
    do_reset();
    plain(e_ldw(8'hFF));
    plain(e_stw(7'h40));
    plain(e_stw(7'h7F));
    check("R11 stw zero", zero, 0);
    step(e_sks(7'h40, 3'd3), 1'b1);
    exp_pc = exp_pc + 13'd2;
    check("R11 stored ones", fetch_addr, exp_pc);
    step('0, 1'b1);
    plain(e_clrf(7'h40));
    check("R8 clrf zero", zero, 1);
    step(e_sks(7'h40, 3'd3), 1'b1);
    exp_pc = exp_pc + 13'd1;
    check("R8 location cleared", fetch_addr, exp_pc);
    plain(e_clrf(7'h7F));
    step(e_skc(7'h7F, 3'd7), 1'b1);
    exp_pc = exp_pc + 13'd2;
    check("R8 top location cleared", fetch_addr, exp_pc);
    step('0, 1'b1);
    plain(e_ldw(8'h00));
    check("R8 zero sticky", zero, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    t_skip_set();
    t_skip_clr();
    t_call();
    t_stack();
    t_clrw();
    t_clrf();
    finish_run();
  end
endmodule